// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the receive side of an Ethernet port and decides, for the 48-bit destination address of each incoming frame, whether the frame is kept. It holds a bank of exact-match address slots and a 64-bit multicast hash table. A small set of mode bits allows every frame (promiscuous), turns hash matching for multicast on, turns broadcast acceptance off, or switches all exact slots off without erasing them. A run-time count splits the slot bank. Slots below the count compare against unicast destinations only, such as the station address in slot 0. Slots at or above the count compare against multicast destinations only.

Configuration is loaded through a simple indexed write port with 32-bit data. The address is presented on one 48-bit bus with a valid strobe. Byte k of the address, in wire order, sits in bits 8k+7..8k. The accept or reject decision appears on a registered output on the cycle after the strobe. An address is multicast when bit 0 of byte 0 is set. An address is broadcast when all 48 bits are ones. All-multicast operation is obtained by loading both hash words with all ones.

Top module: `rx_addr_filter`

## Requirements
- R1: `dec_valid` is high exactly on the cycle after a cycle with `addr_valid` high. `dec_accept` carries that address's decision and is low whenever `dec_valid` is low.
- R2: Slot i is loaded by two writes. Index 2i carries the low word, holding address bytes 3,2,1,0 from most to least significant. Index 2i+1 carries the high word, holding bytes 5,4 in bits 15:0. A unicast address equal to a slot below the count is accepted, and any single-bit difference from it is not matched.
- R3: Index 19 sets the unicast slot count. Values 0 to 8 are taken. A write above 8 is refused, and the previous count stays. The count is 1 after reset.
- R4: Slots at or above the count match only multicast addresses. Slots below it match only unicast addresses.
- R5: Mode bit 3 (index 18) enables exact matching. When it is cleared, no slot matches. When it is set again, the earlier slot contents match again with no reload.
- R6: Mode bit 0 (promiscuous) accepts every address.
- R7: Broadcast is accepted unless mode bit 2 is set. A broadcast address held in an active slot is still accepted while bit 2 is set.
- R8: The hash index bit j is the XOR of all address bits at running position k (byte-major, bit 0 first within each byte) with k mod 6 = j. Index 0 to 31 selects that bit of the word at index 16. Index 32 to 63 selects bit (index-32) of the word at index 17. When mode bit 1 is set, a multicast address whose selected table bit is set is accepted. When mode bit 1 is clear, no address is accepted through the table.
- R9: The hash table never accepts a unicast address, even with every table bit set.
- R10: With both hash words all ones and mode bit 1 set, every multicast address is accepted.
- R11: After reset, every slot, both hash words and mode bits 2..0 are zero, and mode bit 3 is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_idx | input | CFG_IDX_W | Configuration register index |
| cfg_wr_data | input | DATA_W | Configuration write data |
| addr_valid | input | 1 | Destination address present |
| dst_addr | input | ADDR_W | Destination address, byte k in bits 8k+7..8k |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Frame accepted |

## Verification
The exact-match path is tried with the programmed address and all 48 single-bit variants of it. This separates a true compare from a partial one or a misplaced byte lane. The hash path is swept over all 64 one-hot table settings. Each setting is tried with an address built to fold onto that bit and with pseudo-random multicast addresses, which exposes any error in the fold order or in the word split. The same slots are presented under several unicast counts, with the exact-enable bit toggled and with broadcast disabled. These runs show whether the slot split, the refusal of a count above 8 and the priority order are each honoured.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef struct packed {
      logic exact_en;
      logic bcast_dis;
      logic hash_en;
      logic promisc;
   } rxf_mode_t;

   localparam int MODE_W = 4;
   localparam rxf_mode_t MODE_RESET = '{exact_en: 1'b1, bcast_dis: 1'b0,
                                         hash_en: 1'b0, promisc: 1'b0};

endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg
   import rxf_pkg::*;
#(
   parameter int N      = 8,
   parameter int ADDR_W = 48,
   parameter int HASH_W = 6,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [N-1:0][ADDR_W-1:0]  entries,
   output logic [(1<<HASH_W)-1:0]    hash_tbl,
   output rxf_mode_t                 mode,
   output logic [CNT_W-1:0]          ucnt
);
   localparam int HASH_BITS  = 1 << HASH_W;
   localparam int HASH_WORDS = HASH_BITS / DATA_W;
   localparam int HI_W       = ADDR_W - DATA_W;
   localparam int IDX_HASH0  = 2 * N;
   localparam int IDX_MODE   = IDX_HASH0 + HASH_WORDS;
   localparam int IDX_UCNT   = IDX_MODE + 1;

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [DATA_W-1:0] lo_q;
      logic [HI_W-1:0]   hi_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_en) begin
            if (wr_idx == IDX_W'(2*i))   lo_q <= wr_data;
            if (wr_idx == IDX_W'(2*i+1)) hi_q <= wr_data[HI_W-1:0];
         end
      end
      assign entries[i] = {hi_q, lo_q};
   end

   for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hword
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(IDX_HASH0 + w))
            word_q <= wr_data;
      end
      assign hash_tbl[w*DATA_W +: DATA_W] = word_q;
   end

   rxf_mode_t        mode_q;
   logic [CNT_W-1:0] ucnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         ucnt_q <= CNT_W'(1);
      end else if (wr_en) begin
         if (wr_idx == IDX_W'(IDX_MODE))
            mode_q <= rxf_mode_t'(wr_data[MODE_W-1:0]);
         if (wr_idx == IDX_W'(IDX_UCNT) && wr_data <= DATA_W'(N))
            ucnt_q <= CNT_W'(wr_data);
      end
   end

   assign mode = mode_q;
   assign ucnt = ucnt_q;
endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
   parameter int ADDR_W = 48,
   parameter int HASH_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [HASH_W-1:0] idx
);
   function automatic logic [ADDR_W-1:0] lane_mask(input int lane);
      logic [ADDR_W-1:0] m;
      for (int k = 0; k < ADDR_W; k++)
         m[k] = ((k % HASH_W) == lane);
      return m;
   endfunction

   for (genvar j = 0; j < HASH_W; j++) begin : g_lane
      localparam logic [ADDR_W-1:0] MASK = lane_mask(j);
      assign idx[j] = ^(addr & MASK);
   end
endmodule

// File: rtl/rxf_exact_bank.sv
module rxf_exact_bank #(
   parameter int N      = 8,
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 4
) (
   input  logic [N-1:0][ADDR_W-1:0] entries,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [CNT_W-1:0]         ucnt,
   input  logic                     enable,
   output logic                     hit
);
   logic [N-1:0] slot_hit;
   logic         addr_mcast;

   assign addr_mcast = addr[0];

   for (genvar i = 0; i < N; i++) begin : g_cmp
      logic ucast_slot;
      assign ucast_slot  = (CNT_W'(i) < ucnt);
      assign slot_hit[i] = (entries[i] == addr) && (ucast_slot != addr_mcast);
   end

   assign hit = enable && (|slot_hit);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int N_ENTRIES = 8,
   parameter int ADDR_W    = 48,
   parameter int HASH_W    = 6,
   parameter int DATA_W    = 32,
   parameter int CFG_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_en,
   input  logic [CFG_IDX_W-1:0] cfg_wr_idx,
   input  logic [DATA_W-1:0]    cfg_wr_data,
   input  logic                 addr_valid,
   input  logic [ADDR_W-1:0]    dst_addr,
   output logic                 dec_valid,
   output logic                 dec_accept
);
   localparam int HASH_BITS  = 1 << HASH_W;
   localparam int HASH_WORDS = HASH_BITS / DATA_W;
   localparam int CNT_W      = $clog2(N_ENTRIES + 1);
   localparam int N_REGS     = 2 * N_ENTRIES + HASH_WORDS + 2;

   if (N_ENTRIES < 1 || N_ENTRIES > 16) begin : g_bad_n
      $error("N_ENTRIES out of range");
   end
   if (DATA_W >= ADDR_W || ADDR_W - DATA_W > DATA_W) begin : g_bad_w
      $error("DATA_W must cover the address in two words");
   end
   if (HASH_BITS % DATA_W != 0) begin : g_bad_h
      $error("hash table must be whole data words");
   end
   if (N_REGS > (1 << CFG_IDX_W)) begin : g_bad_idx
      $error("CFG_IDX_W too narrow for the register set");
   end

   logic [N_ENTRIES-1:0][ADDR_W-1:0] entries;
   logic [HASH_BITS-1:0]             hash_tbl;
   rxf_mode_t                        mode_q;
   logic [CNT_W-1:0]                 ucnt;
   logic [HASH_W-1:0]                hash_idx;
   logic                             exact_hit;
   logic                             accept_c;
   logic                             is_bcast;
   logic                             is_mcast;
   logic [MODE_W-1:0]                mode_bits;

   rxf_cfg #(
      .N(N_ENTRIES), .ADDR_W(ADDR_W), .HASH_W(HASH_W),
      .DATA_W(DATA_W), .IDX_W(CFG_IDX_W), .CNT_W(CNT_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
      .wr_data(cfg_wr_data), .entries(entries), .hash_tbl(hash_tbl),
      .mode(mode_q), .ucnt(ucnt)
   );

   rxf_hash_fold #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_fold (
      .addr(dst_addr), .idx(hash_idx)
   );

   rxf_exact_bank #(.N(N_ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bank (
      .entries(entries), .addr(dst_addr), .ucnt(ucnt),
      .enable(mode_q.exact_en), .hit(exact_hit)
   );

   assign is_bcast  = &dst_addr;
   assign is_mcast  = dst_addr[0];
   assign mode_bits = mode_q;

   always_comb begin
      if (mode_q.promisc)
         accept_c = 1'b1;
      else if (exact_hit)
         accept_c = 1'b1;
      else if (is_bcast)
         accept_c = !mode_q.bcast_dis;
      else if (is_mcast)
         accept_c = mode_q.hash_en && hash_tbl[hash_idx];
      else
         accept_c = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= addr_valid;
         dec_accept <= addr_valid && accept_c;
      end
   end
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
   parameter int N      = 8,
   parameter int ADDR_W = 48,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_valid,
   input logic [ADDR_W-1:0] dst_addr,
   input logic              dec_valid,
   input logic              dec_accept,
   input logic [3:0]        mode_bits,
   input logic              exact_hit,
   input logic [CNT_W-1:0]  ucnt
);
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |=> dec_valid);

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid |=> !dec_valid);

   p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !dec_accept);

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ucnt <= CNT_W'(N));

   p_promisc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && mode_bits[0] |=> dec_accept);

   p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && (&dst_addr) && !mode_bits[2] |=> dec_accept);

   p_ucast_no_hash_r9: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && !mode_bits[0] && !exact_hit && !dst_addr[0] |=> !dec_accept);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(
   .N(N_ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dst_addr(dst_addr),
   .dec_valid(dec_valid), .dec_accept(dec_accept), .mode_bits(mode_bits),
   .exact_hit(exact_hit), .ucnt(ucnt)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [4:0]  cfg_wr_idx = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        addr_valid = 1'b0;
   logic [47:0] dst_addr = '0;
   logic        dec_valid;
   logic        dec_accept;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 0;

   logic [47:0] m_ent [8];
   logic [63:0] m_hash;
   logic [3:0]  m_mode;
   int          m_cnt;
   logic [63:0] seed = 64'h1234_5678_9abc_def1;

   always #5 clk = ~clk;

   rx_addr_filter u_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
      .cfg_wr_data(cfg_wr_data), .addr_valid(addr_valid), .dst_addr(dst_addr),
      .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         $display("FAIL R1 watchdog: actual %0d cycles, expected completion", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [5:0] fold(input logic [47:0] a);
      logic [5:0] h = '0;
      int k = 0;
      for (int o = 0; o < 6; o++)
         for (int b = 0; b < 8; b++) begin
            h[k % 6] ^= a[o*8 + b];
            k++;
         end
      return h;
   endfunction

   function automatic bit model(input logic [47:0] a);
      bit mc = a[0];
      bit bc = (a == 48'hFFFF_FFFF_FFFF);
      bit hit = 0;
      if (m_mode[3])
         for (int i = 0; i < 8; i++)
            if (m_ent[i] == a && ((i < m_cnt) ? !mc : mc)) hit = 1;
      if (m_mode[0]) return 1;
      if (hit) return 1;
      if (bc) return !m_mode[2];
      if (mc) return m_mode[1] && m_hash[fold(a)];
      return 0;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] data);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_idx = 5'(idx); cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (idx < 16) begin
         if (idx % 2 == 0) m_ent[idx/2][31:0] = data;
         else              m_ent[idx/2][47:32] = data[15:0];
      end else if (idx == 16) m_hash[31:0]  = data;
      else if (idx == 17)     m_hash[63:32] = data;
      else if (idx == 18)     m_mode = data[3:0];
      else if (idx == 19 && data <= 32'd8) m_cnt = int'(data);
   endtask

   task automatic set_slot(input int i, input logic [47:0] a);
      wr(2*i, a[31:0]);
      wr(2*i+1, {16'h0, a[47:32]});
   endtask

   task automatic lookup(input logic [47:0] a, input string tag);
      bit exp = model(a);
      @(negedge clk);
      addr_valid = 1'b1; dst_addr = a;
      @(negedge clk);
      addr_valid = 1'b0;
      check(dec_valid === 1'b1, {tag, " valid"}, 64'(dec_valid), 64'd1);
      check(dec_accept === exp, tag, 64'(dec_accept), 64'(exp));
   endtask

   function automatic logic [47:0] rnd();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
      return seed[63:16];
   endfunction

   initial begin
      logic [47:0] sta = 48'h5634_1200_AB02;
      logic [47:0] mca = 48'h0000_5E00_0101;
      logic [47:0] uni2 = 48'h2233_4455_6670;
      logic [47:0] a;
      for (int i = 0; i < 8; i++) m_ent[i] = '0;
      m_hash = '0; m_mode = 4'b1000; m_cnt = 1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 / R1: reset state
      check(dec_valid === 1'b0, "R1 reset valid", 64'(dec_valid), 0);
      check(dec_accept === 1'b0, "R11 reset accept", 64'(dec_accept), 0);
      lookup(48'hFFFF_FFFF_FFFF, "R11 bcast after reset");
      lookup(48'h0, "R11 zero slot0 unicast");
      lookup(48'h0000_0000_0100, "R11 other unicast");
      @(negedge clk);
      check(dec_valid === 1'b0, "R1 idle valid low", 64'(dec_valid), 0);

      // R2: slot 0 station address and single-bit neighbours
      set_slot(0, sta);
      lookup(sta, "R2 station match");
      for (int b = 0; b < 48; b++) lookup(sta ^ (48'd1 << b), "R2 bit flip");

      // R3 / R4: split of slot bank
      set_slot(3, mca);
      set_slot(5, uni2);
      lookup(mca, "R4 mcast slot above count");
      lookup(uni2, "R4 unicast in mcast slot");
      wr(19, 4);
      lookup(mca, "R4 mcast in unicast slot");
      wr(19, 9);
      lookup(mca, "R3 refused count keeps 4");
      wr(19, 32'hFFFF_FFFF);
      lookup(mca, "R3 refused large count");
      wr(19, 8);
      lookup(uni2, "R3 count 8 unicast slot5");
      lookup(sta, "R3 count 8 station");
      wr(19, 0);
      lookup(sta, "R4 count 0 station not unicast");
      wr(19, 1);
      lookup(sta, "R4 count 1 station");
      lookup(mca, "R4 count 1 mcast");

      // R5: exact disable preserves contents
      wr(18, 32'h0);
      lookup(sta, "R5 disabled station");
      lookup(mca, "R5 disabled mcast");
      wr(18, 32'h8);
      lookup(sta, "R5 reenabled station");
      lookup(mca, "R5 reenabled mcast");

      // R6: promiscuous
      wr(18, 32'h9);
      for (int i = 0; i < 8; i++) lookup(rnd(), "R6 promisc");
      wr(18, 32'h8);

      // R7: broadcast rule and exact override
      wr(18, 32'hC);
      lookup(48'hFFFF_FFFF_FFFF, "R7 bcast disabled");
      set_slot(6, 48'hFFFF_FFFF_FFFF);
      lookup(48'hFFFF_FFFF_FFFF, "R7 bcast in slot");
      set_slot(6, 48'h0);
      lookup(48'hFFFF_FFFF_FFFF, "R7 bcast slot cleared");
      wr(18, 32'h8);

      // R8: one-hot hash sweep
      wr(18, 32'hA);
      for (int b = 0; b < 64; b++) begin
         wr(16, (b < 32) ? (32'd1 << b) : 32'd0);
         wr(17, (b >= 32) ? (32'd1 << (b-32)) : 32'd0);
         a = {42'd0, 6'(b)} | 48'd1;
         if (b[0] == 1'b0) a = a | 48'h40;
         lookup(a, "R8 built address");
         for (int r = 0; r < 3; r++) lookup(rnd() | 48'd1, "R8 random mcast");
      end

      // R10 / R9: all-multicast
      wr(16, 32'hFFFF_FFFF);
      wr(17, 32'hFFFF_FFFF);
      for (int i = 0; i < 16; i++) lookup(rnd() | 48'd1, "R10 all mcast");
      for (int i = 0; i < 16; i++) lookup(rnd() & ~48'd1, "R9 unicast no hash");
      wr(18, 32'h8);
      for (int i = 0; i < 4; i++) lookup(rnd() | 48'd1, "R8 hash disabled");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule